// File: doc/BRIEF.md
# Indexed Vector Gather/Scatter Sequencer

This block carries out one indexed vector memory operation at a time. A load gathers elements into a small vector register array. A store scatters elements from that array to memory. Each element address is the scalar base plus a signed offset taken from an index vector. An element may carry several consecutive fields, forming a segment. Elements can be masked off individually.

The operation runs in two passes. The first pass presents every active element's address range to an external fault checker. Only if none of them faults does the second pass move any data. The second pass makes one access per element field over a ready/valid memory port, with a single request outstanding. After a load, the unused tail of every field is cleared to zero.

The register array has a second port for the surrounding vector datapath. That port writes operands and reads results, with one cycle of read latency.

Top module: `vidx_gather_scatter`

## Requirements
- R1: The address of element i is `cmd_base` plus the low SEW bits of index slot i, taken as signed and sign-extended. Index slot i is `cmd_index[i*DW +: DW]`. The SEW code `cmd_sew` is the log2 of the size in bytes: 0 means 8 bits, 1 means 16, 2 means 32.
- R2: A command with `cmd_vl`=0 raises `done` in the cycle after it is accepted. It produces no probe, no memory request and no register write.
- R3: With `cmd_vm`=0, an element whose `cmd_mask` bit is 0 gets no probe and no access, and all of its register slots keep their values. With `cmd_vm`=1, every element below vl is active.
- R4: Each active element is probed once, in ascending order, with `probe_size` = nf << msz bytes. All probing finishes before the first memory request.
- R5: If `probe_fault` is high for a probed element, the operation ends without any memory request or register write. At `done`, `fault`=1 and `fault_elem` gives that element's index. `fault` returns to 0 when the next command is accepted.
- R6: Field k of element i uses address (element address + k << msz). For a load it writes register slot i + k*vlmax; for a store it reads that slot.
- R7: Requests are issued in increasing element order. Within an element they are issued in increasing field order.
- R8: After a load, slots vl to vlmax-1 of every field read zero. Slots at or above nf*vlmax are untouched.
- R9: A store leaves the register array unchanged. It writes the low (1 << msz) bytes of the slot, little-endian.
- R10: Loaded data narrower than SEW is sign-extended up to SEW when `cmd_unsigned`=0 and zero-extended when it is 1. Bits above SEW are zero.
- R11: `cmd_ready` is high only while idle. A command with vl>0 makes it fall in the next cycle. `done` lasts exactly one cycle.
- R12: A request held while `mem_req_ready` is low keeps `mem_req_valid`, address and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Idle, command accepted |
| cmd_store | input | 1 | 1 = scatter store, 0 = gather load |
| cmd_unsigned | input | 1 | Zero-extend loaded data |
| cmd_sew | input | 2 | Element width code (log2 bytes) |
| cmd_msz | input | 2 | Memory access size code (log2 bytes) |
| cmd_nf | input | NW | Fields per element, 1..NFM |
| cmd_vl | input | LW | Active element count |
| cmd_vlmax | input | LW | Slot stride between fields |
| cmd_vm | input | 1 | 1 = unmasked |
| cmd_mask | input | VLM | Per-element enable bits |
| cmd_base | input | AW | Scalar base address |
| cmd_index | input | VLM*DW | Index vector, one DW slot per element |
| probe_valid | output | 1 | Address check request |
| probe_addr | output | AW | First byte to check |
| probe_size | output | PSW | Byte count to check |
| probe_store | output | 1 | Check is for a write |
| probe_fault | input | 1 | Same-cycle fault answer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Write request |
| mem_req_addr | output | AW | Request byte address |
| mem_req_size | output | 2 | Access size code (log2 bytes) |
| mem_req_wdata | output | DW | Store data, low bytes used |
| mem_rsp_valid | input | 1 | Response or write acknowledge |
| mem_rsp_data | input | DW | Load data, low bytes used |
| vr_we | input | 1 | Datapath write to register array |
| vr_addr | input | SLW | Datapath slot address |
| vr_wdata | input | DW | Datapath write data |
| vr_rdata | output | DW | Datapath read data, one cycle latency |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation stopped on a fault |
| fault_elem | output | IW | Index of faulting element |

## Verification
`cmd_ready` falls in the cycle after acceptance, and `done` is due one cycle after the final write or tail clear. For vl=0, `done` is due in the very next cycle. Array contents are read back through the datapath port, with each value valid one cycle after its address. The bench drives inputs and samples outputs on falling edges. It checks the exact `done` cycle and the busy flag at fixed offsets from acceptance. For the variable-length passes it waits for `done`, then confirms that the pulse has cleared one cycle later. Probe and request order are logged at each accepted handshake and compared after completion.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_SEL,
    ST_REQ,
    ST_WAIT,
    ST_CLR,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int VLM = 8,
  parameter int NW  = 3,
  localparam int IW = $clog2(VLM)
) (
  input  logic [AW-1:0]     base,
  input  logic [VLM*DW-1:0] index_flat,
  input  logic [IW-1:0]     elem,
  input  logic [NW-1:0]     field,
  input  logic [1:0]        sew,
  input  logic [1:0]        msz,
  output logic [AW-1:0]     addr
);
  logic [DW-1:0] raw;
  logic [AW-1:0] offs;
  logic [AW-1:0] foff;

  always_comb begin
    raw = index_flat[elem*DW +: DW];
    case (sew)
      2'd0:    offs = AW'($signed(raw[7:0]));
      2'd1:    offs = AW'($signed(raw[15:0]));
      default: offs = AW'($signed(raw));
    endcase
    foff = AW'(field) << msz;
    addr = base + offs + foff;
  end
endmodule

// File: rtl/vgs_load_ext.sv
module vgs_load_ext #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    msz,
  input  logic [1:0]    sew,
  input  logic          uns,
  output logic [DW-1:0] dout
);
  int  mbits;
  int  sbits;
  logic sgn;

  always_comb begin
    mbits = 8 << msz;
    sbits = 8 << sew;
    if (mbits > DW) mbits = DW;
    sgn = din[mbits-1];
    for (int b = 0; b < DW; b++) begin
      if (b < mbits)      dout[b] = din[b];
      else if (b < sbits) dout[b] = sgn & ~uns;
      else                dout[b] = 1'b0;
    end
  end
endmodule

// File: rtl/vgs_vreg.sv
module vgs_vreg #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AWID = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            a_we,
  input  logic [AWID-1:0] a_addr,
  input  logic [DW-1:0]   a_wdata,
  output logic [DW-1:0]   a_rdata,
  input  logic            b_we,
  input  logic [AWID-1:0] b_addr,
  input  logic [DW-1:0]   b_wdata,
  output logic [DW-1:0]   b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port (sequencer first), two synchronous read ports
  always_ff @(posedge clk) begin
    if (b_we)      mem[b_addr] <= b_wdata;
    else if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/vidx_gather_scatter.sv
module vidx_gather_scatter #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int VLM = 8,
  parameter int NFM = 4,
  localparam int LW    = $clog2(VLM + 1),
  localparam int NW    = $clog2(NFM + 1),
  localparam int IW    = $clog2(VLM),
  localparam int SLOTS = VLM * NFM,
  localparam int SLW   = $clog2(SLOTS),
  localparam int PSW   = $clog2(NFM * (DW / 8) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_store,
  input  logic              cmd_unsigned,
  input  logic [1:0]        cmd_sew,
  input  logic [1:0]        cmd_msz,
  input  logic [NW-1:0]     cmd_nf,
  input  logic [LW-1:0]     cmd_vl,
  input  logic [LW-1:0]     cmd_vlmax,
  input  logic              cmd_vm,
  input  logic [VLM-1:0]    cmd_mask,
  input  logic [AW-1:0]     cmd_base,
  input  logic [VLM*DW-1:0] cmd_index,
  output logic              probe_valid,
  output logic [AW-1:0]     probe_addr,
  output logic [PSW-1:0]    probe_size,
  output logic              probe_store,
  input  logic              probe_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              vr_we,
  input  logic [SLW-1:0]    vr_addr,
  input  logic [DW-1:0]     vr_wdata,
  output logic [DW-1:0]     vr_rdata,
  output logic              done,
  output logic              fault,
  output logic [IW-1:0]     fault_elem
);
  import vgs_pkg::*;

  seq_state_e st;

  // latched command
  logic              store_r, uns_r, vm_r;
  logic [1:0]        sew_r, msz_r;
  logic [NW-1:0]     nf_r;
  logic [LW-1:0]     vl_r, vlmax_r;
  logic [VLM-1:0]    mask_r;
  logic [AW-1:0]     base_r;
  logic [VLM*DW-1:0] index_r;

  // walk position
  logic [LW-1:0] cur_i;
  logic [NW-1:0] cur_k;
  logic [AW-1:0] mem_addr_r;
  logic          done_r, fault_r;
  logic [IW-1:0] fault_elem_r;

  logic          elem_active, last_elem, last_field, tail_needed, last_tail;
  logic [AW-1:0] gen_addr;
  logic [SLW-1:0] slot;
  logic [DW-1:0] ext_data, b_rdata, b_wdata;
  logic          b_we;

  always_comb begin
    elem_active = vm_r | mask_r[cur_i[IW-1:0]];
    last_elem   = (cur_i == vl_r - LW'(1));
    last_field  = (cur_k == nf_r - NW'(1));
    last_tail   = (cur_i == vlmax_r - LW'(1));
    tail_needed = !store_r && (vl_r < vlmax_r);
    slot        = SLW'(cur_i) + SLW'(cur_k) * SLW'(vlmax_r);
  end

  vgs_addr_gen #(.AW(AW), .DW(DW), .VLM(VLM), .NW(NW)) u_agen (
    .base       (base_r),
    .index_flat (index_r),
    .elem       (cur_i[IW-1:0]),
    .field      (cur_k),
    .sew        (sew_r),
    .msz        (msz_r),
    .addr       (gen_addr)
  );

  vgs_load_ext #(.DW(DW)) u_ext (
    .din  (mem_rsp_data),
    .msz  (msz_r),
    .sew  (sew_r),
    .uns  (uns_r),
    .dout (ext_data)
  );

  assign b_we    = (st == ST_CLR) || (st == ST_WAIT && mem_rsp_valid && !store_r);
  assign b_wdata = (st == ST_CLR) ? '0 : ext_data;

  vgs_vreg #(.DW(DW), .DEPTH(SLOTS)) u_vreg (
    .clk     (clk),
    .a_we    (vr_we),
    .a_addr  (vr_addr),
    .a_wdata (vr_wdata),
    .a_rdata (vr_rdata),
    .b_we    (b_we),
    .b_addr  (slot),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      done_r       <= 1'b0;
      fault_r      <= 1'b0;
      fault_elem_r <= '0;
      cur_i        <= '0;
      cur_k        <= '0;
      mem_addr_r   <= '0;
      store_r      <= 1'b0;
      uns_r        <= 1'b0;
      vm_r         <= 1'b1;
      sew_r        <= '0;
      msz_r        <= '0;
      nf_r         <= NW'(1);
      vl_r         <= '0;
      vlmax_r      <= '0;
      mask_r       <= '0;
      base_r       <= '0;
      index_r      <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            store_r <= cmd_store;
            uns_r   <= cmd_unsigned;
            vm_r    <= cmd_vm;
            sew_r   <= cmd_sew;
            msz_r   <= cmd_msz;
            nf_r    <= cmd_nf;
            vl_r    <= cmd_vl;
            vlmax_r <= cmd_vlmax;
            mask_r  <= cmd_mask;
            base_r  <= cmd_base;
            index_r <= cmd_index;
            fault_r <= 1'b0;
            cur_i   <= '0;
            cur_k   <= '0;
            if (cmd_vl == '0) done_r <= 1'b1;
            else              st     <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (elem_active && probe_fault) begin
            fault_r      <= 1'b1;
            fault_elem_r <= cur_i[IW-1:0];
            st           <= ST_FIN;
          end else if (last_elem) begin
            cur_i <= '0;
            st    <= ST_SEL;
          end else begin
            cur_i <= cur_i + LW'(1);
          end
        end
        ST_SEL: begin
          if (elem_active) begin
            mem_addr_r <= gen_addr;
            st         <= ST_REQ;
          end else if (last_elem) begin
            cur_i <= vl_r;
            cur_k <= '0;
            st    <= tail_needed ? ST_CLR : ST_FIN;
          end else begin
            cur_i <= cur_i + LW'(1);
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!last_field) begin
              cur_k <= cur_k + NW'(1);
              st    <= ST_SEL;
            end else begin
              cur_k <= '0;
              if (last_elem) begin
                cur_i <= vl_r;
                st    <= tail_needed ? ST_CLR : ST_FIN;
              end else begin
                cur_i <= cur_i + LW'(1);
                st    <= ST_SEL;
              end
            end
          end
        end
        ST_CLR: begin
          if (last_tail) begin
            cur_i <= vl_r;
            if (last_field) st <= ST_FIN;
            else            cur_k <= cur_k + NW'(1);
          end else begin
            cur_i <= cur_i + LW'(1);
          end
        end
        ST_FIN: begin
          done_r <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // outputs
  assign cmd_ready     = (st == ST_IDLE);
  assign probe_valid   = (st == ST_PROBE) && elem_active;
  assign probe_addr    = gen_addr;
  assign probe_size    = PSW'(nf_r) << msz_r;
  assign probe_store   = store_r;
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_we    = store_r;
  assign mem_req_addr  = mem_addr_r;
  assign mem_req_size  = msz_r;
  assign done          = done_r;
  assign fault         = fault_r;
  assign fault_elem    = fault_elem_r;

  always_comb begin
    for (int j = 0; j < DW / 8; j++)
      mem_req_wdata[8*j +: 8] = (j < (1 << msz_r)) ? b_rdata[8*j +: 8] : 8'h00;
  end

  // checker support: data movement has begun for this command
  logic moved_r;
  always_ff @(posedge clk) begin
    if (rst)                        moved_r <= 1'b0;
    else if (cmd_valid && cmd_ready) moved_r <= 1'b0;
    else if (mem_req_valid)          moved_r <= 1'b1;
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  p_probe_first_r4: assert property (@(posedge clk) disable iff (rst)
    probe_valid |-> !moved_r);

  p_fault_no_access_r5: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_req_valid && !b_we));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_vl != '0) |=> !cmd_ready);

  p_store_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (store_r && !cmd_ready) |-> !b_we);
endmodule

// File: tb/vidx_gather_scatter_test.sv
module vidx_gather_scatter_test;
  localparam int AW = 32, DW = 32, VLM = 8, NFM = 4;
  localparam int LW = 4, NW = 3, IW = 3, SLW = 5, PSW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              cmd_valid = 0, cmd_ready, cmd_store = 0, cmd_unsigned = 0, cmd_vm = 1;
  logic [1:0]        cmd_sew = 0, cmd_msz = 0;
  logic [NW-1:0]     cmd_nf = 1;
  logic [LW-1:0]     cmd_vl = 0, cmd_vlmax = 0;
  logic [VLM-1:0]    cmd_mask = 0;
  logic [AW-1:0]     cmd_base = 0;
  logic [VLM*DW-1:0] cmd_index = 0;
  logic              probe_valid, probe_store, probe_fault;
  logic [AW-1:0]     probe_addr;
  logic [PSW-1:0]    probe_size;
  logic              mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [AW-1:0]     mem_req_addr;
  logic [1:0]        mem_req_size;
  logic [DW-1:0]     mem_req_wdata, mem_rsp_data;
  logic              vr_we = 0;
  logic [SLW-1:0]    vr_addr = 0;
  logic [DW-1:0]     vr_wdata = 0, vr_rdata;
  logic              done, fault;
  logic [IW-1:0]     fault_elem;

  vidx_gather_scatter #(.AW(AW), .DW(DW), .VLM(VLM), .NFM(NFM)) uut (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  int req_cnt = 0, probe_cnt = 0;
  logic [7:0] req_log [32];
  logic [PSW-1:0] last_psize;
  logic order_bad;
  logic clr_logs = 0;
  logic flt_en = 0;
  int flt_lo = 0, flt_hi = 0;
  logic [7:0] bmem [256];

  function automatic logic [7:0] pat(int a);
    return 8'(((a & 255) * 7 + 3) & 255);
  endfunction
  function automatic logic [31:0] word(int a);
    return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  endfunction

  always_comb begin
    probe_fault = flt_en && probe_valid &&
                  (int'(probe_addr[7:0]) <= flt_hi) &&
                  (int'(probe_addr[7:0]) + int'(probe_size) - 1 >= flt_lo);
  end

  // memory and log model
  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) bmem[a] <= pat(a);
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      req_cnt <= 0; probe_cnt <= 0; order_bad <= 1'b0; last_psize <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_req_ready <= (cyc % 3) != 2;
      mem_rsp_valid <= 1'b0;
      if (clr_logs) begin
        req_cnt <= 0; probe_cnt <= 0; order_bad <= 1'b0;
      end else begin
        if (probe_valid) begin
          probe_cnt  <= probe_cnt + 1;
          last_psize <= probe_size;
          if (req_cnt != 0) order_bad <= 1'b1;
        end
        if (mem_req_valid && mem_req_ready) begin
          req_log[req_cnt[4:0]] <= mem_req_addr[7:0];
          req_cnt <= req_cnt + 1;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_we) begin
          for (int j = 0; j < (1 << mem_req_size); j++)
            bmem[(int'(mem_req_addr[7:0]) + j) & 255] <= mem_req_wdata[8*j +: 8];
        end else begin
          for (int j = 0; j < 4; j++)
            mem_rsp_data[8*j +: 8] <= (j < (1 << mem_req_size)) ?
              bmem[(int'(mem_req_addr[7:0]) + j) & 255] : 8'h00;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic vwrite(input int s, input logic [31:0] v);
    @(negedge clk); vr_we = 1; vr_addr = SLW'(s); vr_wdata = v;
    @(negedge clk); vr_we = 0;
  endtask

  task automatic vread(input int s, output logic [31:0] v);
    @(negedge clk); vr_addr = SLW'(s);
    @(negedge clk); v = vr_rdata;
  endtask

  task automatic setcmd(input logic st, input logic un, input int sew, input int msz,
                        input int nf, input int vl, input int vlmax, input logic vm,
                        input logic [7:0] mask, input int base);
    cmd_store = st; cmd_unsigned = un; cmd_sew = 2'(sew); cmd_msz = 2'(msz);
    cmd_nf = NW'(nf); cmd_vl = LW'(vl); cmd_vlmax = LW'(vlmax); cmd_vm = vm;
    cmd_mask = mask; cmd_base = AW'(base);
  endtask

  task automatic go(input string req);
    int n;
    @(negedge clk); clr_logs = 1; cmd_valid = 1;
    @(negedge clk); clr_logs = 0; cmd_valid = 0;
    if (cmd_vl == 0) chk({req, " R2 done next cycle"}, 32'(done), 1);
    else             chk({req, " R11 busy after accept"}, 32'(cmd_ready), 0);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk({req, " R11 done one cycle"}, 32'(done), 0);
  endtask

  task automatic t_reset;
    chk("R11 reset ready", 32'(cmd_ready), 1);
    chk("R11 reset done", 32'(done), 0);
    chk("R12 reset req", 32'(mem_req_valid), 0);
    chk("R4 reset probe", 32'(probe_valid), 0);
  endtask

  task automatic t_vl_zero;
    logic [31:0] v;
    vwrite(0, 32'hCAFE0000);
    setcmd(0, 0, 2, 2, 1, 0, 4, 1, 8'h00, 'h40);
    go("vl0");
    chk("R2 no request", 32'(req_cnt), 0);
    chk("R2 no probe", 32'(probe_cnt), 0);
    vread(0, v); chk("R2 slot kept", v, 32'hCAFE0000);
  endtask

  task automatic t_basic_load;
    logic [31:0] v;
    int ad [4] = '{'h40, 'h48, 'h3C, 'h60};
    for (int s = 0; s < 8; s++) vwrite(s, 32'hDEAD0000 + s);
    cmd_index = '0;
    cmd_index[0*32 +: 32] = 32'd0;  cmd_index[1*32 +: 32] = 32'd8;
    cmd_index[2*32 +: 32] = -32'sd4; cmd_index[3*32 +: 32] = 32'h20;
    setcmd(0, 0, 2, 2, 1, 4, 6, 1, 8'h00, 'h40);
    go("basic");
    chk("R4 probe count", 32'(probe_cnt), 4);
    chk("R4 probe size", 32'(last_psize), 4);
    chk("R4 probes before data", 32'(order_bad), 0);
    for (int i = 0; i < 4; i++) begin
      chk("R7 request order", 32'(req_log[i]), 32'(ad[i]));
      vread(i, v); chk("R1 loaded word", v, word(ad[i]));
    end
    for (int s = 4; s < 6; s++) begin vread(s, v); chk("R8 tail zero", v, 0); end
    vread(6, v); chk("R8 beyond vlmax kept", v, 32'hDEAD0006);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    for (int s = 0; s < 4; s++) vwrite(s, 32'hBEEF0000 + s);
    cmd_index = '0;
    for (int i = 0; i < 4; i++) cmd_index[i*32 +: 32] = 32'(4 * i);
    setcmd(0, 0, 2, 2, 1, 4, 4, 0, 8'b0000_0101, 'h80);
    go("masked");
    chk("R3 probe count", 32'(probe_cnt), 2);
    chk("R3 request count", 32'(req_cnt), 2);
    vread(0, v); chk("R3 active elem0", v, word('h80));
    vread(1, v); chk("R3 masked elem1 kept", v, 32'hBEEF0001);
    vread(2, v); chk("R3 active elem2", v, word('h88));
    vread(3, v); chk("R3 masked elem3 kept", v, 32'hBEEF0003);
  endtask

  task automatic t_extend(input logic un);
    logic [31:0] v, e;
    int ad [2] = '{'h10, 'h13};
    cmd_index = '0;
    cmd_index[0*32 +: 32] = 0; cmd_index[1*32 +: 32] = 3;
    setcmd(0, un, 1, 0, 1, 2, 2, 1, 8'h00, 'h10);
    go(un ? "zext" : "sext");
    for (int i = 0; i < 2; i++) begin
      e = {24'h0, pat(ad[i])};
      if (!un && pat(ad[i])[7]) e[15:8] = 8'hFF;
      vread(i, v); chk(un ? "R10 zero extend" : "R10 sign extend", v, e);
    end
  endtask

  task automatic t_segment;
    logic [31:0] v;
    int ea [3] = '{'hA0, 'hB0, 'h90};
    for (int s = 0; s < 13; s++) vwrite(s, 32'h600D0000 + s);
    cmd_index = '0;
    cmd_index[0*32 +: 32] = 32'hFFFFFF00;
    cmd_index[1*32 +: 32] = 32'h00000010;
    cmd_index[2*32 +: 32] = 32'h000000F0;
    setcmd(0, 0, 0, 0, 3, 3, 4, 1, 8'h00, 'hA0);
    go("segment");
    chk("R4 segment probe size", 32'(last_psize), 3);
    chk("R6 request count", 32'(req_cnt), 9);
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < 3; k++) begin
        chk("R7 element then field order", 32'(req_log[i*3+k]), 32'((ea[i] + k) & 255));
        vread(i + 4*k, v); chk("R6 field slot", v, {24'h0, pat(ea[i] + k)});
      end
    for (int k = 0; k < 3; k++) begin vread(3 + 4*k, v); chk("R8 field tail zero", v, 0); end
    vread(12, v); chk("R8 slot past nf*vlmax kept", v, 32'h600D000C);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    for (int s = 0; s < 4; s++) vwrite(s, 32'h55550000 + s);
    cmd_index = '0;
    for (int i = 0; i < 4; i++) cmd_index[i*32 +: 32] = 32'(4 * i);
    flt_en = 1; flt_lo = 'h0A; flt_hi = 'h0A;
    setcmd(0, 0, 2, 2, 1, 4, 4, 1, 8'h00, 'h00);
    go("fault");
    flt_en = 0;
    chk("R5 fault flag", 32'(fault), 1);
    chk("R5 fault element", 32'(fault_elem), 2);
    chk("R5 no request", 32'(req_cnt), 0);
    chk("R5 probes stop at fault", 32'(probe_cnt), 3);
    for (int s = 0; s < 4; s++) begin vread(s, v); chk("R5 slots kept", v, 32'h55550000 + s); end
  endtask

  task automatic t_store;
    logic [31:0] v;
    for (int s = 0; s < 4; s++) vwrite(s, 32'h7777C0D0 + s);
    cmd_index = '0;
    for (int i = 0; i < 3; i++) cmd_index[i*32 +: 32] = 32'(4 * i);
    setcmd(1, 0, 2, 1, 1, 3, 4, 1, 8'h00, 'hC0);
    go("store");
    chk("R5 fault cleared", 32'(fault), 0);
    chk("R9 request count", 32'(req_cnt), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 low byte", 32'(bmem['hC0 + 4*i]), 32'(8'hD0 + i));
      chk("R9 high byte", 32'(bmem['hC1 + 4*i]), 32'hC0);
      chk("R9 beyond size kept", 32'(bmem['hC2 + 4*i]), 32'(pat('hC2 + 4*i)));
    end
    for (int s = 0; s < 4; s++) begin vread(s, v); chk("R9 array unchanged", v, 32'h7777C0D0 + s); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_vl_zero();
    t_basic_load();
    t_masked();
    t_extend(1'b0);
    t_extend(1'b1);
    t_segment();
    t_fault();
    t_store();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule